// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block is a synchronous controller for a 64K-word by 16-bit EDO DRAM. The DRAM has an 8-bit multiplexed address bus, a row strobe and one column strobe per byte lane. On the host side, each transfer is a single request: an address, a per-byte enable mask, write data and a valid/ready handshake. Reads come back with a one-cycle valid strobe. The controller turns each request into row-strobe, column-strobe, write-enable and output-enable sequences on the DRAM pins. Every timing limit is a parameter counted in whole clock cycles.

A page stays open after an access. A later request to the same row is served as an EDO page-mode column cycle, with the row strobe held low. A request to a different row closes the page, waits out the precharge, and then opens the new row. An interval timer raises refresh requests. A pending refresh outranks host traffic and is carried out as a CAS-before-RAS cycle once the page is closed and precharged.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row (address bits 15..8) is on `dram_addr` when `dram_ras_n` falls. The column (address bits 7..0) is on `dram_addr` when the column strobes fall.
- R2: `dram_cas_n[0]` serves data bits 7..0 and `dram_cas_n[1]` serves bits 15..8. In a host access, a lane's strobe goes low exactly when its `req_be` bit is 1. A disabled lane's strobe stays high for the whole access.
- R3: A read returns `rsp_valid` high for exactly one cycle. Its data is the DRAM bus as sampled `T_RDLAT` cycles after the column strobe fell, with every byte whose enable was 0 forced to zero. Byte-lane writes merge correctly with the untouched lane.
- R4: On a write, `dram_we_n` is low and `dram_dq_oe` is high at least one cycle before the column strobe falls (early write).
- R5: Successive requests to the open row do not reopen the row. Column strobes stay high for at least `T_CP` cycles, and successive column-strobe falls are at least `T_PC` cycles apart.
- R6: A request to a different row raises `dram_ras_n`. The strobe stays high for at least `T_RP` cycles before the next fall, and every such request opens a row.
- R7: Successive `dram_ras_n` falls are at least `T_RC` cycles apart, and `dram_ras_n` stays low for at least `T_RC - T_RP` cycles.
- R8: A column strobe falls at least `T_RCD` cycles after `dram_ras_n` falls, and stays low for at least `T_CAS` cycles.
- R9: One refresh is done per `REF_CYCLES` interval. Both column strobes are low for a cycle before `dram_ras_n` falls, and `dram_we_n` is high.
- R10: A due refresh outranks host requests: `req_ready` is low while it is pending. The k-th refresh begins no earlier than k*`REF_CYCLES` cycles and no more than a few tens of cycles later.
- R11: After reset, all strobes and `dram_we_n`/`dram_oe_n` are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_be | input | DATA_W/LANE_W | Byte enables, bit 0 = bits 7..0 |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, disabled bytes zero |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | DATA_W/LANE_W | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enables the data pad drivers |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench sweeps full 256-column rows at the lowest, a middle and the highest row address. It writes a word pattern computed from the address and reads it back, which separates row bits from column bits and shows that a sweep of hits keeps the page open. Alternating reads between two distant rows force every access to be a miss. This shows the precharge and cycle spacing under back-to-back closes. Lower-only, upper-only and full-word writes and reads on one row tell lane steering, lane merging and the zeroing of disabled bytes apart. Long idle stretches and steady traffic together place each refresh against its due time.

// File: rtl/edo_dram_pkg.sv
// Shared types for the EDO DRAM controller.
package edo_dram_pkg;

    // Sequencer states of the controller
    typedef enum logic [2:0] {
        ST_IDLE,     // page closed, precharged
        ST_RCD,      // row open, waiting row-to-column delay
        ST_COL,      // column address and write controls set up, strobes high
        ST_CAS,      // column strobes low
        ST_PAGE,     // page open, column strobes high
        ST_PRE,      // row strobe high, counting precharge
        ST_REF_CAS,  // refresh: column strobes low ahead of row strobe
        ST_REF_RAS   // refresh: row strobe low
    } ctrl_state_e;

endpackage

// File: rtl/edo_addr_split.sv
// Splits a host word address into row and column and zero-extends each
// to the width of the multiplexed DRAM address bus.
// Assumes the row sits in the upper address bits.
module edo_addr_split #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int PIN_W = 8
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [PIN_W-1:0]       row_pin,
    output logic [PIN_W-1:0]       col_pin
);

    // Slice and pad the two address phases
    always_comb begin
        row                  = addr[ROW_W+COL_W-1:COL_W];
        row_pin              = '0;
        row_pin[ROW_W-1:0]   = addr[ROW_W+COL_W-1:COL_W];
        col_pin              = '0;
        col_pin[COL_W-1:0]   = addr[COL_W-1:0];
    end

endmodule

// File: rtl/edo_refresh_timer.sv
// Free-running refresh interval timer. Raises a pending flag once every
// REF_CYCLES clocks and holds it until the sequencer acknowledges.
// Assumes the acknowledge is a single-cycle pulse.
module edo_refresh_timer #(
    parameter int REF_CYCLES = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);

    localparam int CNT_W = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1;

    logic [CNT_W-1:0] interval_cnt;

    // Count the interval and set or clear the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_cnt <= '0;
            ref_pend     <= 1'b0;
        end else begin
            if (int'(interval_cnt) == REF_CYCLES - 1) begin
                interval_cnt <= '0;
                ref_pend     <= 1'b1;
            end else begin
                interval_cnt <= interval_cnt + 1'b1;
                if (ref_ack) begin
                    ref_pend <= 1'b0;
                end
            end
        end
    end

    AST_ACK_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ref_pend); // R9

endmodule

// File: rtl/edo_rd_capture.sv
// Captures DRAM read data on a strobe from the sequencer, zeroes the
// byte lanes whose enable is clear, and emits a one-cycle valid.
// Assumes capture strobes are never on consecutive cycles.
module edo_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_en,
    input  logic [DATA_W/LANE_W-1:0]   lane_en,
    input  logic [DATA_W-1:0]          dq_in,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata
);

    localparam int LANES = DATA_W / LANE_W;

    // Valid strobe follows the capture by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= cap_en;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register one byte lane, forced to zero when not enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (cap_en) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3

endmodule

// File: rtl/edo_dram_ctrl.sv
// EDO page-mode DRAM controller. Accepts single word/byte requests,
// opens rows, runs column cycles with per-lane strobes, keeps the page
// open for row hits, and interleaves CAS-before-RAS refresh.
// Assumes: T_RDLAT in 1..T_CAS, all timing parameters at least 1,
// and all DRAM outputs registered so the pins change only on clock edges.
module edo_dram_ctrl
    import edo_dram_pkg::*;
#(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 8,
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_CP       = 1,
    parameter int T_PC       = 2,
    parameter int T_RC       = 6,
    parameter int T_RDLAT    = 2,
    parameter int REF_CYCLES = 1560,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int LANES     = DATA_W / LANE_W,
    localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic [LANES-1:0]  dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    // Derived timing: column precharge covers both tCP and the page cycle
    localparam int CP_PC   = (T_PC > T_CAS) ? (T_PC - T_CAS) : 0;
    localparam int CP_A    = (T_CP > CP_PC) ? T_CP : CP_PC;
    localparam int CP_EFF  = (CP_A > 2) ? CP_A : 2;
    localparam int RAS_MIN = (T_RC > T_RP + 1) ? (T_RC - T_RP) : 1;
    localparam int RCD_HLD = (T_RCD > 2) ? (T_RCD - 2) : 0;
    localparam int M1      = (T_RP > RAS_MIN) ? T_RP : RAS_MIN;
    localparam int M2      = (T_CAS > CP_EFF) ? T_CAS : CP_EFF;
    localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
    localparam int TMR_W   = $clog2(CNT_MAX + 1);
    localparam int RC_W    = $clog2(T_RC + 1);

    ctrl_state_e        state;
    logic [TMR_W-1:0]   tmr;
    logic [RC_W-1:0]    rc_cnt;
    logic [ROW_W-1:0]   open_row;
    logic [PIN_W-1:0]   cur_col;
    logic [LANES-1:0]   cur_be;
    logic               cur_write;
    logic [DATA_W-1:0]  cur_wdata;

    logic [ROW_W-1:0]   req_row;
    logic [PIN_W-1:0]   req_row_pin;
    logic [PIN_W-1:0]   req_col_pin;
    logic               ref_pend;
    logic               ref_ack;
    logic               rc_ok;
    logic               row_hit;
    logic               page_free;
    logic               accept_idle;
    logic               accept_page;
    logic               ras_open;
    logic               cap_en;

    edo_addr_split #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .PIN_W  (PIN_W)
    ) u_split (
        .addr    (req_addr),
        .row     (req_row),
        .row_pin (req_row_pin),
        .col_pin (req_col_pin)
    );

    edo_refresh_timer #(
        .REF_CYCLES (REF_CYCLES)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    edo_rd_capture #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .lane_en   (cur_be),
        .dq_in     (dram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Acceptance and strobe decisions
    always_comb begin
        rc_ok       = int'(rc_cnt) >= T_RC;
        row_hit     = (req_row == open_row);
        page_free   = (state == ST_PAGE) && (tmr == '0);
        req_ready   = ((state == ST_IDLE) && !ref_pend && rc_ok) ||
                      (page_free && !ref_pend && row_hit);
        accept_idle = req_valid && (state == ST_IDLE) && !ref_pend && rc_ok;
        accept_page = req_valid && page_free && !ref_pend && row_hit;
        ras_open    = accept_idle || (state == ST_REF_CAS);
        ref_ack     = (state == ST_REF_CAS);
        cap_en      = (state == ST_CAS) && !cur_write &&
                      (tmr == TMR_W'(T_CAS - T_RDLAT));
    end

    // Row cycle counter: cycles since the last row strobe fall, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_cnt <= RC_W'(T_RC);
        end else if (ras_open) begin
            rc_cnt <= RC_W'(1);
        end else if (int'(rc_cnt) < T_RC) begin
            rc_cnt <= rc_cnt + 1'b1;
        end
    end

    // Main sequencer with registered DRAM pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tmr         <= '0;
            open_row    <= '0;
            cur_col     <= '0;
            cur_be      <= '0;
            cur_write   <= 1'b0;
            cur_wdata   <= '0;
            dram_addr   <= '0;
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= '1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_pend && rc_ok) begin
                        dram_cas_n <= '0;
                        state      <= ST_REF_CAS;
                    end else if (accept_idle) begin
                        open_row   <= req_row;
                        cur_col    <= req_col_pin;
                        cur_be     <= req_be;
                        cur_write  <= req_write;
                        cur_wdata  <= req_wdata;
                        dram_addr  <= req_row_pin;
                        dram_ras_n <= 1'b0;
                        tmr        <= TMR_W'(RCD_HLD);
                        state      <= ST_RCD;
                    end
                end
                ST_RCD: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        dram_addr   <= cur_col;
                        dram_we_n   <= !cur_write;
                        dram_oe_n   <= cur_write;
                        dram_dq_out <= cur_wdata;
                        dram_dq_oe  <= cur_write;
                        state       <= ST_COL;
                    end
                end
                ST_COL: begin
                    dram_cas_n <= ~cur_be;
                    tmr        <= TMR_W'(T_CAS - 1);
                    state      <= ST_CAS;
                end
                ST_CAS: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        dram_cas_n <= '1;
                        dram_we_n  <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dram_dq_oe <= 1'b0;
                        tmr        <= TMR_W'(CP_EFF - 2);
                        state      <= ST_PAGE;
                    end
                end
                ST_PAGE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (ref_pend || (req_valid && !row_hit)) begin
                        if (int'(rc_cnt) >= RAS_MIN) begin
                            dram_ras_n <= 1'b1;
                            tmr        <= TMR_W'(T_RP - 1);
                            state      <= ST_PRE;
                        end
                    end else if (accept_page) begin
                        cur_be      <= req_be;
                        cur_write   <= req_write;
                        dram_addr   <= req_col_pin;
                        dram_we_n   <= !req_write;
                        dram_oe_n   <= req_write;
                        dram_dq_out <= req_wdata;
                        dram_dq_oe  <= req_write;
                        state       <= ST_COL;
                    end
                end
                ST_PRE: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_REF_CAS: begin
                    dram_ras_n <= 1'b0;
                    tmr        <= TMR_W'(RAS_MIN - 1);
                    state      <= ST_REF_RAS;
                end
                ST_REF_RAS: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        dram_ras_n <= 1'b1;
                        dram_cas_n <= '1;
                        tmr        <= TMR_W'(T_RP - 1);
                        state      <= ST_PRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REF_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready); // R10

    AST_CBR_CAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && (dram_cas_n != '1)) |-> (($past(dram_cas_n) == '0) && dram_we_n)); // R9

    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dram_cas_n) == '1) && (dram_cas_n != '1) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe)); // R4

    AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (int'($past(rc_cnt)) >= T_RC)); // R7

    AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAS) |-> (dram_cas_n == ~cur_be)); // R2

endmodule

// File: tb/edo_dram_ctrl_tb.sv
// Bench for edo_dram_ctrl: behavioural DRAM model, pin timing monitor,
// address-pattern sweeps and byte-lane checks.
module edo_dram_ctrl_tb;

    localparam int T_RP    = 3;
    localparam int T_RCD   = 2;
    localparam int T_CAS   = 2;
    localparam int T_CP    = 1;
    localparam int T_PC    = 2;
    localparam int T_RC    = 6;
    localparam int T_RDLAT = 2;
    localparam int REF     = 300;
    localparam int SLACK   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [7:0]  dram_addr;
    logic        dram_ras_n;
    logic [1:0]  dram_cas_n;
    logic        dram_we_n;
    logic        dram_oe_n;
    logic [15:0] dram_dq_out;
    logic        dram_dq_oe;
    logic [15:0] dq_in_r = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edo_dram_ctrl #(
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_PC(T_PC),
        .T_RC(T_RC), .T_RDLAT(T_RDLAT), .REF_CYCLES(REF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] + a[7:0]};
    endfunction

    // DRAM model storage and monitor state
    logic [15:0] mem [int unsigned];
    logic [7:0]  exp_row = '0;
    logic [7:0]  exp_col = '0;
    logic [1:0]  exp_be = '0;
    logic [7:0]  mrow = '0;
    logic        prev_ras, prev_we, prev_rsp;
    logic [1:0]  prev_cas;
    int cyc = 0;
    int ras_hi_run, ras_lo_run, cas_hi_run, cas_lo_run;
    int last_ras_fall, last_cas_fall;
    int ref_count = 0;
    int row_opens = 0;
    int cas_falls = 0;

    // Model the DRAM and check pin timing once per cycle, away from the edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1; prev_cas = 2'b11; prev_we = 1'b1; prev_rsp = 1'b0;
            cyc = 0; ras_hi_run = 100; ras_lo_run = 0; cas_hi_run = 100; cas_lo_run = 0;
            last_ras_fall = -100; last_cas_fall = -100;
        end else begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
                chk(ras_hi_run >= T_RP, "R6", "row precharge", ras_hi_run, T_RP);
                chk(cyc - last_ras_fall >= T_RC, "R7", "row cycle", cyc - last_ras_fall, T_RC);
                if (dram_cas_n != 2'b11) begin
                    ref_count++;
                    chk(prev_cas == 2'b00 && dram_cas_n == 2'b00 && dram_we_n, "R9",
                        "CAS before RAS order", {prev_cas, dram_cas_n, dram_we_n}, 5'b00001);
                    chk(cyc >= ref_count * REF && cyc <= ref_count * REF + SLACK, "R10",
                        "refresh start cycle", cyc, ref_count * REF);
                end else begin
                    row_opens++;
                    chk(dram_addr == exp_row, "R1", "row address", dram_addr, exp_row);
                    mrow = dram_addr;
                end
                last_ras_fall = cyc;
            end
            if (!prev_ras && dram_ras_n)
                chk(ras_lo_run >= T_RC - T_RP, "R7", "row low time", ras_lo_run, T_RC - T_RP);
            if (prev_cas == 2'b11 && dram_cas_n != 2'b11 && !dram_ras_n) begin
                int unsigned k;
                logic [15:0] w;
                k = int'({mrow, dram_addr});
                w = mem.exists(k) ? mem[k] : 16'h0;
                chk(cyc - last_ras_fall >= T_RCD, "R8", "row to column", cyc - last_ras_fall, T_RCD);
                chk(cas_hi_run >= T_CP, "R5", "column precharge", cas_hi_run, T_CP);
                chk(cyc - last_cas_fall >= T_PC, "R5", "page cycle", cyc - last_cas_fall, T_PC);
                chk(dram_addr == exp_col, "R1", "column address", dram_addr, exp_col);
                chk(dram_cas_n == ~exp_be, "R2", "lane strobes", dram_cas_n, ~exp_be);
                if (!dram_we_n) begin
                    chk(!prev_we && dram_dq_oe, "R4", "early write setup", {prev_we, dram_dq_oe}, 2'b01);
                    if (!dram_cas_n[0]) w[7:0] = dram_dq_out[7:0];
                    if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
                    mem[k] = w;
                end else begin
                    dq_in_r = w;
                end
                cas_falls++;
                last_cas_fall = cyc;
            end
            if (prev_cas != 2'b11 && dram_cas_n == 2'b11)
                chk(cas_lo_run >= T_CAS, "R8", "column low time", cas_lo_run, T_CAS);
            if (prev_cas != 2'b11 && dram_cas_n != 2'b11)
                chk(dram_cas_n == prev_cas, "R2", "lane strobe stable", dram_cas_n, prev_cas);
            if (rsp_valid) begin
                chk(cyc - last_cas_fall == T_RDLAT, "R3", "read latency", cyc - last_cas_fall, T_RDLAT);
                chk(!prev_rsp, "R3", "single-cycle valid", prev_rsp, 0);
            end
            ras_hi_run = dram_ras_n ? (prev_ras ? ras_hi_run + 1 : 1) : 0;
            ras_lo_run = !dram_ras_n ? (!prev_ras ? ras_lo_run + 1 : 1) : 0;
            cas_hi_run = (dram_cas_n == 2'b11) ? ((prev_cas == 2'b11) ? cas_hi_run + 1 : 1) : 0;
            cas_lo_run = (dram_cas_n != 2'b11) ? ((prev_cas != 2'b11) ? cas_lo_run + 1 : 1) : 0;
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n; prev_rsp = rsp_valid;
        end
    end

    // One host transfer: handshake, wait for its column strobe, then its data
    task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] be,
                          input logic [15:0] wd, output logic [15:0] rd);
        int n0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        exp_row = a[15:8]; exp_col = a[7:0]; exp_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        n0 = cas_falls;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        while (cas_falls == n0) begin
            @(negedge clk);
            #1;
        end
        rd = 16'h0;
        if (!wr) begin
            while (!rsp_valid) begin
                @(negedge clk);
                #1;
            end
            rd = rsp_rdata;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        logic [7:0] rows [3];
        int o0, f0;
        rows[0] = 8'h00; rows[1] = 8'h5A; rows[2] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: idle state after reset
        chk(dram_ras_n == 1'b1, "R11", "ras after reset", dram_ras_n, 1);
        chk(dram_cas_n == 2'b11, "R11", "cas after reset", dram_cas_n, 3);
        chk(dram_we_n && dram_oe_n, "R11", "we/oe after reset", {dram_we_n, dram_oe_n}, 3);
        chk(!dram_dq_oe && !rsp_valid, "R11", "dq_oe/rsp after reset", {dram_dq_oe, rsp_valid}, 0);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

        // R1 R5: full-row word sweeps, page held open across hits
        for (int r = 0; r < 3; r++) begin
            o0 = row_opens; f0 = ref_count;
            for (int c = 0; c < 256; c++)
                access(1'b1, {rows[r], 8'(c)}, 2'b11, pat({rows[r], 8'(c)}), rd);
            chk(row_opens - o0 <= ref_count - f0 + 1, "R5", "row opens in write sweep",
                row_opens - o0, ref_count - f0 + 1);
        end
        for (int r = 0; r < 3; r++) begin
            o0 = row_opens; f0 = ref_count;
            for (int c = 0; c < 256; c++) begin
                access(1'b0, {rows[r], 8'(c)}, 2'b11, 16'h0, rd);
                chk(rd == pat({rows[r], 8'(c)}), "R1", "word readback", rd, pat({rows[r], 8'(c)}));
            end
            chk(row_opens - o0 <= ref_count - f0 + 1, "R5", "row opens in read sweep",
                row_opens - o0, ref_count - f0 + 1);
        end

        // R6: alternating rows, every access a miss
        o0 = row_opens;
        for (int i = 0; i < 16; i++) begin
            access(1'b0, {(i % 2 == 0) ? 8'h00 : 8'hFF, 8'(i * 7)}, 2'b11, 16'h0, rd);
            chk(rd == pat({(i % 2 == 0) ? 8'h00 : 8'hFF, 8'(i * 7)}), "R6", "miss readback",
                rd, pat({(i % 2 == 0) ? 8'h00 : 8'hFF, 8'(i * 7)}));
        end
        chk(row_opens - o0 == 16, "R6", "row opens on misses", row_opens - o0, 16);

        // R2 R3: byte-lane writes merge, disabled lanes read as zero
        for (int c = 0; c < 32; c++) begin
            logic [7:0] lo, hi;
            lo = 8'(c) ^ 8'h5A;
            hi = ~8'(c);
            access(1'b1, {8'h33, 8'(c)}, 2'b11, 16'h0000, rd);
            access(1'b1, {8'h33, 8'(c)}, 2'b01, {8'hEE, lo}, rd);
            access(1'b1, {8'h33, 8'(c)}, 2'b10, {hi, 8'hEE}, rd);
            access(1'b0, {8'h33, 8'(c)}, 2'b11, 16'h0, rd);
            chk(rd == {hi, lo}, "R2", "merged lanes", rd, {hi, lo});
            access(1'b0, {8'h33, 8'(c)}, 2'b01, 16'h0, rd);
            chk(rd == {8'h00, lo}, "R3", "lower-only read", rd, {8'h00, lo});
            access(1'b0, {8'h33, 8'(c)}, 2'b10, 16'h0, rd);
            chk(rd == {hi, 8'h00}, "R3", "upper-only read", rd, {hi, 8'h00});
        end

        // R9: idle stretch, refresh count follows elapsed time
        repeat (3 * REF) @(negedge clk);
        chk(ref_count == cyc / REF || ref_count == cyc / REF - 1, "R9", "refresh count",
            ref_count, cyc / REF);
        access(1'b0, {8'h5A, 8'h80}, 2'b11, 16'h0, rd);
        chk(rd == pat({8'h5A, 8'h80}), "R1", "readback after refreshes", rd, pat({8'h5A, 8'h80}));
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule